// File: doc/BRIEF.md
# Serial EEPROM Configuration Block Loader

After reset this block fetches a byte stream from a serial EEPROM one byte at a time. It reads the stream as a chain of typed configuration blocks and turns each block into 32-bit register writes on an internal CSR bus. Three block kinds exist. A single block writes one dword. A sequential block writes a counted run of dwords at consecutive addresses. A done block closes the stream and carries a checksum.

The CSR address is a 14-bit system address. Its two top bits pick one of the per-port spaces: port A at 0x0000, port B at 0x1000 and port C at 0x2000. The fourth space, 0x3000 and above, is never a target. For every other address the loader asks an external lookup whether the register exists, and a missing register is skipped. When the stream ends, through a good checksum, a bad checksum or a block type it does not know, the loader raises a sticky `done`, drops `busy` and stays quiet until the next reset.

Top module: `cfgld_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ee_rd_req` and `csr_wr_valid` are low, `busy` is high, and `done`, `halt_req` and the three error flags are low.
- R2: Byte reads start at EEPROM byte address 0. Each accepted byte (`ee_rd_req` and `ee_rd_ack` high in the same cycle) advances `ee_rd_addr` by one. `ee_rd_req` and `ee_rd_addr` hold steady until the acknowledge arrives.
- R3: `ee_dev` is the 7-bit EEPROM bus address. Bits [4:1] equal `strap_addr`, and bits 6, 5 and 0 come from a parameter (default 0x50, which gives {2'b10, strap, 1'b0}).
- R4: Header byte 0 holds the block type in bits [1:0] and address bits [7:2] in bits [7:2]. Address bits [1:0] are always zero. Header byte 1 bits [5:0] are address bits [13:8]. Type 0 (single) is followed by four data bytes, least significant first, and produces one write.
- R5: Type 1 (sequential) has a 16-bit dword count after the header, low byte first, and then count × 4 data bytes. The n-th dword goes to address base + 4n, wrapping at 14 bits. A count of 0 produces no write.
- R6: `csr_wr_valid` stays high with `csr_wr_addr` and `csr_wr_data` stable until `csr_wr_ready` is high. `ee_rd_req` is low whenever `csr_wr_valid` is high.
- R7: A target whose bits [13:12] equal 3, or for which `csr_map_hit` is low, gets no write. Such a target sets the sticky `err_unmapped`, and parsing goes on with the next dword or block.
- R8: Type 2 (done) is header byte 0, one ignored byte, and a checksum byte. The checksum is good when the sum modulo 256 of the checksum byte and every byte before the done block is zero. A good checksum sets `done`, clears `busy`, and leaves `halt_req` and `err_cksum` low.
- R9: A bad checksum sets `err_cksum`, `halt_req` and `done`.
- R10: Type 3 sets `err_format` and `done` as soon as that header byte arrives. `halt_req` stays low and no later byte is read.
- R11: Once `done` is high it stays high, and neither `ee_rd_req` nor `csr_wr_valid` is asserted again until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_addr | input | 4 | Strap bits for EEPROM bus address [4:1] |
| ee_dev | output | 7 | EEPROM bus address for the byte reader |
| ee_rd_req | output | 1 | Byte read request |
| ee_rd_addr | output | EE_AW (16) | EEPROM byte address |
| ee_rd_ack | input | 1 | One-cycle strobe: `ee_rd_data` is valid |
| ee_rd_data | input | 8 | Byte returned |
| csr_wr_valid | output | 1 | CSR write request |
| csr_wr_ready | input | 1 | CSR bus accepts the write |
| csr_wr_addr | output | CSR_AW (14) | CSR system byte address, also the lookup key |
| csr_wr_data | output | DW (32) | CSR write data |
| csr_map_hit | input | 1 | Combinational lookup: `csr_wr_addr` is a defined register |
| busy | output | 1 | High from reset until done |
| done | output | 1 | Load finished, sticky |
| halt_req | output | 1 | Reset-halt control request (bad checksum) |
| err_unmapped | output | 1 | A write to an undefined register was dropped |
| err_cksum | output | 1 | Checksum mismatch |
| err_format | output | 1 | Unknown block type |

## Verification
On every cycle the assertions enforce the handshake rules:
- requests and writes are held steady until accepted, and the read and write requests never overlap;
- the read address steps by one per accepted byte;
- every issued write is aligned and lands in a mapped space;
- the terminal state stays silent, and the strap mapping holds.

Only the bench scenarios can show that the parsed content is correct. Those scenarios cover:
- the addresses and data of each write, including the 14-bit wrap inside a sequential run and a zero count;
- the checksum verdict;
- how far the stream was read before a format abort.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

   // Block type codes carried in header byte 0 bits [1:0]
   typedef enum logic [1:0] {
      BT_SINGLE = 2'd0,
      BT_SEQ    = 2'd1,
      BT_DONE   = 2'd2,
      BT_BAD    = 2'd3
   } blk_type_e;

   // Which byte of the current block comes next
   typedef enum logic [2:0] {
      PH_HDR0,
      PH_HDR1,
      PH_CNT0,
      PH_CNT1,
      PH_DATA,
      PH_CKS
   } phase_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_WRITE,
      ST_END
   } state_e;

   localparam int CNT_W = 16;

endpackage

// File: rtl/cfgld_fetch.sv
// Byte fetch: request pointer and running byte sum
module cfgld_fetch #(
   parameter int EE_AW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             want,
   input  logic             rd_ack,
   input  logic [7:0]       rd_data,
   output logic             rd_req,
   output logic [EE_AW-1:0] rd_addr,
   output logic             byte_vld,
   output logic [7:0]       byte_q,
   output logic [7:0]       sum_q
);
   logic [EE_AW-1:0] ptr_q;
   logic [7:0]       acc_q;

   assign rd_req   = want;
   assign byte_vld = want & rd_ack;
   assign byte_q   = rd_data;
   assign rd_addr  = ptr_q;
   assign sum_q    = acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         acc_q <= '0;
      end else if (byte_vld) begin
         ptr_q <= ptr_q + EE_AW'(1);
         acc_q <= acc_q + rd_data;
      end
   end
endmodule

// File: rtl/cfgld_wport.sv
// CSR write port: mapping decision and valid/ready completion
module cfgld_wport #(
   parameter int SEL_W  = 2,
   parameter int SPACES = 3
) (
   input  logic             arm,
   input  logic [SEL_W-1:0] sel,
   input  logic             map_hit,
   input  logic             wr_ready,
   output logic             wr_valid,
   output logic             fin,
   output logic             skip
);
   logic space_ok;
   logic mapped;

   assign space_ok = (int'(sel) < SPACES);
   assign mapped   = map_hit & space_ok;
   assign wr_valid = arm & mapped;
   assign skip     = arm & ~mapped;
   assign fin      = arm & (~mapped | wr_ready);
endmodule

// File: rtl/cfgld_seq.sv
// Block parser and sequencing state machine
module cfgld_seq
   import cfgld_pkg::*;
#(
   parameter int CSR_AW = 14,
   parameter int DW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic [7:0]        byte_q,
   input  logic [7:0]        sum_q,
   input  logic              fin,
   input  logic              skip,
   output logic              want,
   output logic              arm,
   output logic [CSR_AW-1:0] tgt_addr,
   output logic [DW-1:0]     tgt_data,
   output logic              fin_done,
   output logic              halt,
   output logic              e_unm,
   output logic              e_cks,
   output logic              e_fmt
);
   localparam int NB     = DW / 8;
   localparam int LANE_W = (NB > 1) ? $clog2(NB) : 1;

   state_e            st_q;
   phase_e            ph_q;
   blk_type_e         typ_q;
   logic [CSR_AW-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [LANE_W-1:0] lane_q;
   logic [7:0]        snap_q;
   logic              halt_q, unm_q, cks_q, fmt_q;
   logic              lane_we;
   logic [7:0]        cks_sum;
   logic [DW-1:0]     data_q;

   assign want     = (st_q == ST_FETCH);
   assign arm      = (st_q == ST_WRITE);
   assign fin_done = (st_q == ST_END);
   assign tgt_addr = addr_q;
   assign tgt_data = data_q;
   assign halt     = halt_q;
   assign e_unm    = unm_q;
   assign e_cks    = cks_q;
   assign e_fmt    = fmt_q;
   assign lane_we  = want & byte_vld & (ph_q == PH_DATA);
   assign cks_sum  = snap_q + byte_q;

   // One register per data byte lane
   for (genvar g = 0; g < NB; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            data_q[g*8 +: 8] <= '0;
         else if (lane_we && (int'(lane_q) == g))
            data_q[g*8 +: 8] <= byte_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ph_q   <= PH_HDR0;
         typ_q  <= BT_SINGLE;
         addr_q <= '0;
         cnt_q  <= '0;
         lane_q <= '0;
         snap_q <= '0;
         halt_q <= 1'b0;
         unm_q  <= 1'b0;
         cks_q  <= 1'b0;
         fmt_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: st_q <= ST_FETCH;
            ST_FETCH: begin
               if (byte_vld) begin
                  case (ph_q)
                     PH_HDR0: begin
                        typ_q       <= blk_type_e'(byte_q[1:0]);
                        addr_q[7:0] <= {byte_q[7:2], 2'b00};
                        snap_q      <= sum_q;
                        if (blk_type_e'(byte_q[1:0]) == BT_BAD) begin
                           fmt_q <= 1'b1;
                           st_q  <= ST_END;
                        end else begin
                           ph_q <= PH_HDR1;
                        end
                     end
                     PH_HDR1: begin
                        addr_q[CSR_AW-1:8] <= byte_q[CSR_AW-9:0];
                        lane_q <= '0;
                        if (typ_q == BT_DONE)     ph_q <= PH_CKS;
                        else if (typ_q == BT_SEQ) ph_q <= PH_CNT0;
                        else                      ph_q <= PH_DATA;
                     end
                     PH_CNT0: begin
                        cnt_q[7:0] <= byte_q;
                        ph_q       <= PH_CNT1;
                     end
                     PH_CNT1: begin
                        cnt_q[15:8] <= byte_q;
                        if ({byte_q, cnt_q[7:0]} == '0) ph_q <= PH_HDR0;
                        else                            ph_q <= PH_DATA;
                     end
                     PH_DATA: begin
                        lane_q <= lane_q + LANE_W'(1);
                        if (int'(lane_q) == NB - 1) st_q <= ST_WRITE;
                     end
                     PH_CKS: begin
                        if (cks_sum != 8'h00) begin
                           cks_q  <= 1'b1;
                           halt_q <= 1'b1;
                        end
                        st_q <= ST_END;
                     end
                     default: ph_q <= PH_HDR0;
                  endcase
               end
            end
            ST_WRITE: begin
               if (fin) begin
                  if (skip) unm_q <= 1'b1;
                  lane_q <= '0;
                  st_q   <= ST_FETCH;
                  if (typ_q == BT_SEQ && cnt_q != CNT_W'(1)) begin
                     cnt_q  <= cnt_q - CNT_W'(1);
                     addr_q <= addr_q + CSR_AW'(4);
                     ph_q   <= PH_DATA;
                  end else begin
                     ph_q <= PH_HDR0;
                  end
               end
            end
            default: st_q <= ST_END;
         endcase
      end
   end
endmodule

// File: rtl/cfgld_top.sv
module cfgld_top #(
   parameter int         EE_AW     = 16,
   parameter int         CSR_AW    = 14,
   parameter int         DW        = 32,
   parameter int         SPACE_LSB = 12,
   parameter int         SPACES    = 3,
   parameter logic [6:0] DEV_FIX   = 7'h50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        strap_addr,
   output logic [6:0]        ee_dev,
   output logic              ee_rd_req,
   output logic [EE_AW-1:0]  ee_rd_addr,
   input  logic              ee_rd_ack,
   input  logic [7:0]        ee_rd_data,
   output logic              csr_wr_valid,
   input  logic              csr_wr_ready,
   output logic [CSR_AW-1:0] csr_wr_addr,
   output logic [DW-1:0]     csr_wr_data,
   input  logic              csr_map_hit,
   output logic              busy,
   output logic              done,
   output logic              halt_req,
   output logic              err_unmapped,
   output logic              err_cksum,
   output logic              err_format
);
   localparam int SEL_W = CSR_AW - SPACE_LSB;

   if (CSR_AW < 10 || CSR_AW > 16) begin : g_bad_aw
      $error("cfgld_top: CSR_AW must lie in 10..16");
   end
   if (DW < 8 || (DW % 8) != 0) begin : g_bad_dw
      $error("cfgld_top: DW must be a multiple of 8");
   end
   if (SPACE_LSB < 2 || SPACE_LSB >= CSR_AW) begin : g_bad_lsb
      $error("cfgld_top: SPACE_LSB out of range");
   end
   if (SPACES < 1 || SPACES >= (1 << SEL_W)) begin : g_bad_sp
      $error("cfgld_top: SPACES must leave one reserved space");
   end
   if (EE_AW < 4) begin : g_bad_ee
      $error("cfgld_top: EE_AW too small");
   end

   logic       want, arm, byte_vld, fin, skip, fin_done;
   logic [7:0] byte_q, sum_q;

   assign ee_dev = {DEV_FIX[6:5], strap_addr, DEV_FIX[0]};

   cfgld_fetch #(.EE_AW(EE_AW)) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .want     (want),
      .rd_ack   (ee_rd_ack),
      .rd_data  (ee_rd_data),
      .rd_req   (ee_rd_req),
      .rd_addr  (ee_rd_addr),
      .byte_vld (byte_vld),
      .byte_q   (byte_q),
      .sum_q    (sum_q)
   );

   cfgld_seq #(.CSR_AW(CSR_AW), .DW(DW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_vld (byte_vld),
      .byte_q   (byte_q),
      .sum_q    (sum_q),
      .fin      (fin),
      .skip     (skip),
      .want     (want),
      .arm      (arm),
      .tgt_addr (csr_wr_addr),
      .tgt_data (csr_wr_data),
      .fin_done (fin_done),
      .halt     (halt_req),
      .e_unm    (err_unmapped),
      .e_cks    (err_cksum),
      .e_fmt    (err_format)
   );

   cfgld_wport #(.SEL_W(SEL_W), .SPACES(SPACES)) u_wport (
      .arm      (arm),
      .sel      (csr_wr_addr[CSR_AW-1:SPACE_LSB]),
      .map_hit  (csr_map_hit),
      .wr_ready (csr_wr_ready),
      .wr_valid (csr_wr_valid),
      .fin      (fin),
      .skip     (skip)
   );

   assign done = fin_done;
   assign busy = ~fin_done;
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
   parameter int         EE_AW     = 16,
   parameter int         CSR_AW    = 14,
   parameter int         DW        = 32,
   parameter int         SPACE_LSB = 12,
   parameter int         SPACES    = 3,
   parameter logic [6:0] DEV_FIX   = 7'h50
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        strap_addr,
   input logic [6:0]        ee_dev,
   input logic              ee_rd_req,
   input logic [EE_AW-1:0]  ee_rd_addr,
   input logic              ee_rd_ack,
   input logic              csr_wr_valid,
   input logic              csr_wr_ready,
   input logic [CSR_AW-1:0] csr_wr_addr,
   input logic [DW-1:0]     csr_wr_data,
   input logic              csr_map_hit,
   input logic              done,
   input logic              halt_req,
   input logic              err_cksum,
   input logic              err_format
);
   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ee_rd_req && !ee_rd_ack |=> ee_rd_req && $stable(ee_rd_addr));

   p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ee_rd_req && ee_rd_ack |=> (ee_rd_addr - $past(ee_rd_addr)) == EE_AW'(1));

   p_dev_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ee_dev[4:1] == strap_addr && ee_dev[6:5] == DEV_FIX[6:5] && ee_dev[0] == DEV_FIX[0]);

   p_wr_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
      csr_wr_valid |-> csr_wr_addr[1:0] == 2'b00);

   p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      csr_wr_valid && !csr_wr_ready |=>
         csr_wr_valid && $stable(csr_wr_addr) && $stable(csr_wr_data));

   p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(csr_wr_valid && ee_rd_req));

   p_wr_mapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      csr_wr_valid |-> csr_map_hit && (int'(csr_wr_addr[CSR_AW-1:SPACE_LSB]) < SPACES));

   p_halt_cks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |-> done && err_cksum);

   p_fmt_nohalt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_format |-> done && !halt_req);

   p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ee_rd_req && !csr_wr_valid);
endmodule

bind cfgld_top cfgld_chk #(
   .EE_AW(EE_AW), .CSR_AW(CSR_AW), .DW(DW),
   .SPACE_LSB(SPACE_LSB), .SPACES(SPACES), .DEV_FIX(DEV_FIX)
) u_chk (.*);

// File: tb/tb_cfgld_top.sv
module tb_cfgld_top;
   localparam int EE_AW  = 16;
   localparam int CSR_AW = 14;
   localparam int DW     = 32;
   localparam int MEMN   = 512;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [3:0]        strap;
   logic [6:0]        ee_dev;
   logic              rd_req;
   logic [EE_AW-1:0]  rd_addr;
   logic              rd_ack;
   logic [7:0]        rd_data;
   logic              wv;
   logic              wr;
   logic [CSR_AW-1:0] wa;
   logic [DW-1:0]     wd;
   logic              hit;
   logic              busy, done, halt, e_unm, e_cks, e_fmt;

   always #5 clk = ~clk;

   cfgld_top dut (
      .clk(clk), .rst_n(rst_n), .strap_addr(strap), .ee_dev(ee_dev),
      .ee_rd_req(rd_req), .ee_rd_addr(rd_addr), .ee_rd_ack(rd_ack), .ee_rd_data(rd_data),
      .csr_wr_valid(wv), .csr_wr_ready(wr), .csr_wr_addr(wa), .csr_wr_data(wd),
      .csr_map_hit(hit), .busy(busy), .done(done), .halt_req(halt),
      .err_unmapped(e_unm), .err_cksum(e_cks), .err_format(e_fmt)
   );

   // Register map model: any address with bits [11:8] == 0xF is a hole
   assign hit = (wa[11:8] != 4'hF);

   logic [7:0]        mem [MEMN];
   int                nchk = 0, nfail = 0;
   int                wp, exp_ptr, lat, rmode, wcnt, sc, e_end;
   logic [7:0]        rsum;
   logic [CSR_AW-1:0] qa [$];
   logic [DW-1:0]     qd [$];
   bit                x_unm, x_cks, x_fmt;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit mapped(input logic [CSR_AW-1:0] a);
      return (a[13:12] != 2'd3) && (a[11:8] != 4'hF);
   endfunction

   task automatic put(input logic [7:0] b);
      mem[wp] = b;
      wp++;
      rsum += b;
   endtask

   task automatic clear_stream();
      for (int i = 0; i < MEMN; i++) mem[i] = 8'hFF;
      wp = 0; rsum = 0; qa.delete(); qd.delete();
      x_unm = 0; x_cks = 0; x_fmt = 0; e_end = 0;
   endtask

   task automatic expect_wr(input logic [CSR_AW-1:0] a, input logic [DW-1:0] d);
      if (mapped(a)) begin qa.push_back(a); qd.push_back(d); end
      else x_unm = 1;
   endtask

   task automatic blk_single(input logic [CSR_AW-1:0] a, input logic [31:0] d);
      put({a[7:2], 2'b00});
      put({2'b00, a[13:8]});
      for (int i = 0; i < 4; i++) put(d[i*8 +: 8]);
      expect_wr({a[13:2], 2'b00}, d);
   endtask

   task automatic blk_seq(input logic [CSR_AW-1:0] a, input int n, input logic [31:0] d0);
      logic [CSR_AW-1:0] cur;
      logic [31:0]       d;
      put({a[7:2], 2'b01});
      put({2'b00, a[13:8]});
      put(n[7:0]);
      put(n[15:8]);
      cur = {a[13:2], 2'b00};
      for (int k = 0; k < n; k++) begin
         d = d0 + k * 32'h0101_0101;
         for (int i = 0; i < 4; i++) put(d[i*8 +: 8]);
         expect_wr(cur, d);
         cur = cur + 14'd4;
      end
   endtask

   task automatic blk_done(input bit bad);
      logic [7:0] c;
      c = 8'h00 - rsum;
      if (bad) c = c ^ 8'h5A;
      put(8'h02);
      put(8'h00);
      put(c);
      x_cks = bad;
      e_end = wp;
   endtask

   task automatic blk_badtype(input logic [CSR_AW-1:0] a);
      put({a[7:2], 2'b11});
      x_fmt = 1;
      e_end = wp;
      put(8'h00); put(8'h11); put(8'h22);
   endtask

   // EEPROM byte responder with programmable latency; checks read address (R2)
   initial begin
      rd_ack = 0; rd_data = 0; wcnt = 0;
      forever begin
         @(negedge clk);
         rd_ack = 0;
         if (!rst_n) wcnt = 0;
         else if (rd_req) begin
            chk(rd_addr == EE_AW'(exp_ptr), "R2", "read address", 64'(rd_addr), 64'(exp_ptr));
            if (wcnt >= lat) begin
               rd_data = (exp_ptr < MEMN) ? mem[exp_ptr] : 8'hFF;
               rd_ack  = 1;
               exp_ptr++;
               wcnt = 0;
            end else wcnt++;
         end
      end
   end

   // CSR side: ready pattern and per-clock comparison against the expected write queue
   initial begin
      logic [CSR_AW-1:0] ea;
      logic [DW-1:0]     ed;
      wr = 1; sc = 0;
      forever begin
         @(negedge clk);
         if (rmode == 0) wr = 1;
         else begin sc++; wr = (sc % 3 == 0); end
         #1;
         if (rst_n && wv)
            chk(!rd_req, "R6", "read during write", 64'(rd_req), 64'd0);
         if (rst_n && done)
            chk(!rd_req && !wv, "R11", "activity after done", 64'({rd_req, wv}), 64'd0);
         if (rst_n && wv && wr) begin
            if (qa.size() == 0)
               chk(0, "R7", "unexpected write", 64'(wa), 64'd0);
            else begin
               ea = qa.pop_front();
               ed = qd.pop_front();
               chk(wa == ea, "R4/R5", "write address", 64'(wa), 64'(ea));
               chk(wd == ed, "R4/R5", "write data", 64'(wd), 64'(ed));
            end
         end
      end
   end

   task automatic run(input logic [3:0] s, input int l, input int m, input string name);
      int n;
      $display("scenario %s", name);
      strap = s; lat = l; rmode = m;
      @(negedge clk);
      rst_n = 0;
      exp_ptr = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!rd_req && !wv, "R1", "request in reset", 64'({rd_req, wv}), 64'd0);
      chk(busy && !done, "R1", "busy/done in reset", 64'({busy, done}), 64'b10);
      chk(!halt && !e_unm && !e_cks && !e_fmt, "R1", "flags in reset",
          64'({halt, e_unm, e_cks, e_fmt}), 64'd0);
      rst_n = 1;
      #1;
      chk(!rd_req && busy, "R1", "first cycle after reset", 64'({rd_req, busy}), 64'b01);
      chk(ee_dev == {2'b10, s, 1'b0}, "R3", "device address", 64'(ee_dev), 64'({2'b10, s, 1'b0}));
      n = 0;
      while (!done && n < 4000) begin @(negedge clk); n++; end
      if (!done) chk(0, "R8", "watchdog: no done", 64'(n), 64'd4000);
      repeat (20) @(negedge clk);
      chk(done && !busy, "R8", "done/busy at end", 64'({done, busy}), 64'b10);
      chk(e_cks == x_cks, "R9", "checksum error", 64'(e_cks), 64'(x_cks));
      chk(halt == x_cks, "R9", "halt request", 64'(halt), 64'(x_cks));
      chk(e_fmt == x_fmt, "R10", "format error", 64'(e_fmt), 64'(x_fmt));
      chk(e_unm == x_unm, "R7", "unmapped flag", 64'(e_unm), 64'(x_unm));
      chk(qa.size() == 0, "R5", "writes missing", 64'(qa.size()), 64'd0);
      chk(int'(rd_addr) == e_end, "R10", "bytes consumed", 64'(rd_addr), 64'(e_end));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      strap = 0; lat = 0; rmode = 0; exp_ptr = 0;
      // R4 R5 R8: mixed blocks, zero count, good checksum
      clear_stream();
      blk_single(14'h0004, 32'hDEAD_BEEF);
      blk_seq(14'h1010, 3, 32'h1122_3344);
      blk_seq(14'h2000, 0, 32'h0);
      blk_single(14'h2ABC, 32'hCAFE_0001);
      blk_done(0);
      run(4'h5, 0, 0, "A");

      // R7: holes and reserved space, 14-bit wrap inside a run, stalls
      clear_stream();
      blk_single(14'h0F00, 32'h0BAD_0BAD);
      blk_seq(14'h3FF8, 3, 32'hA0A0_0000);
      blk_single(14'h1234, 32'h5555_AAAA);
      blk_done(0);
      run(4'hA, 2, 1, "B");

      // R9: bad checksum
      clear_stream();
      blk_single(14'h0100, 32'h0000_0001);
      blk_seq(14'h0200, 2, 32'hFFFF_FFFE);
      blk_done(1);
      run(4'h0, 1, 1, "C");

      // R10: unknown type aborts
      clear_stream();
      blk_single(14'h0040, 32'h7777_8888);
      blk_badtype(14'h0080);
      run(4'hF, 0, 0, "D");

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule